// File: doc/BRIEF.md
# Serial EEPROM SPI Command Front End

This block is the slave-side command interface of a small serial EEPROM of 256 or 512 bytes. It runs on the chip clock and oversamples the chip-select, serial clock and serial input pins through a synchronizer. It accepts an 8-bit instruction at the start of every select window and decodes six commands: set the write-enable latch, clear it, read the status byte, write the status byte, read the array and write the array. On the 512-byte variant, the ninth address bit travels inside the instruction byte.

Reads stream array bytes, or the status byte, out on the serial output. Writes are not programmed here. Each received data byte is handed to a separate write controller as a page-load pulse. A one-cycle start pulse then commits the page, or the new status protection bits, when the select window closes. The write controller reports its busy state back. The block uses that state as the ready bit, refuses commands while it is set, and clears the write-enable latch when it falls. The array is a synchronous RAM whose write port belongs to the write controller. Protection checking is also done outside this block.

The serial clock half period must be at least `SYNC_STAGES + 3` chip clock cycles. On the 256-byte variant, a read or write instruction with bit 3 set counts as an unknown code.

Top module: `eeprom_spi_front`

## Requirements
- R1: Serial input is sampled on synchronized SCK rising edges and the serial output changes only after SCK falling edges, MSB first, so that SPI modes 0 and 3 both work. The output enable only ever rises after a falling edge.
- R2: The output enable is low whenever select is high, and it falls within one cycle after the synchronized select rises. It also stays low through the instruction and address bytes.
- R3: Read (0000_x011) followed by an address byte drives array data from the falling edge after the last address bit. The address increments once per byte and wraps from MEM_BYTES-1 to 0 until select rises.
- R4: With MEM_BYTES=512, bit 3 of the read and write instructions is address bit 8 and the following byte is address bits 7:0.
- R5: Any other instruction byte makes the block ignore the rest of that select window. The output stays disabled, no write pulse is issued, and a later enable-latch code in the same window has no effect.
- R6: Read-status (0x05) returns {4'b1111, bp_i[1], bp_i[0], enable latch, busy} and repeats it for every further byte.
- R7: The enable latch is 0 after reset. It is set by 0x06 and cleared by 0x04, and both take effect when select rises.
- R8: Write (0000_x010) is accepted only with the enable latch set. Each full data byte then gives one pg_load pulse, with its address incrementing inside a PAGE_BYTES page and wrapping back to the page start. wr_start pulses once when select rises after at least one full data byte. Without the latch, no pulse is issued.
- R9: Write-status (0x01) with the enable latch set and one full data byte pulses sr_start when select rises, with sr_bp taken from data bits 3:2. Without the latch, nothing is issued.
- R10: While wc_busy is high, every instruction except read-status is ignored, and read-status shows busy in bit 0.
- R11: A falling edge of wc_busy clears the enable latch.
- R12: If select rises in the middle of a byte, nothing is committed and the next window decodes its instruction from the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for the serial data out pad |
| bp_i | input | 2 | Stored protection bits shown in the status byte |
| wc_busy | input | 1 | Write controller busy |
| pg_load | output | 1 | One-cycle pulse per received write data byte |
| pg_addr | output | ADDR_W | Address of the loaded byte |
| pg_data | output | 8 | Loaded byte |
| wr_start | output | 1 | Commit pulse for an array write |
| sr_start | output | 1 | Commit pulse for a status write |
| sr_bp | output | 2 | Protection bits to be stored |
| mem_we | input | 1 | Array write strobe from the write controller |
| mem_waddr | input | ADDR_W | Array write address |
| mem_wdata | input | 8 | Array write data |

## Verification
On every cycle, the assertions check four things. The serial output moves only after a falling clock edge. The output enable drops when select rises. Page loads happen only with the enable latch set and the controller idle. A falling busy clears the latch. The bench scenarios cover the rest: data values and their order in both SPI modes, address wrap at the top of memory and inside a page, the status byte contents, ignored and aborted windows, and refusal of commands while busy.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;
    localparam logic [7:0] OP_SET_WEL = 8'h06;
    localparam logic [7:0] OP_CLR_WEL = 8'h04;
    localparam logic [7:0] OP_RD_STAT = 8'h05;
    localparam logic [7:0] OP_WR_STAT = 8'h01;
    localparam logic [2:0] OP_RD_LOW  = 3'b011;
    localparam logic [2:0] OP_WR_LOW  = 3'b010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_WDATA,
        ST_WSTAT,
        ST_SROUT,
        ST_RDOUT,
        ST_HOLD
    } fe_state_e;

    localparam fe_state_e ST_SKIP = ST_HOLD;

    typedef enum logic [2:0] {
        CM_NONE,
        CM_SET_WEL,
        CM_CLR_WEL,
        CM_ARRAY,
        CM_STATUS
    } commit_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int          WIDTH  = 3,
    parameter int          STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= RST_VAL;
            end else begin
                if (g == 0) stage_q[g] <= pin_i;
                else        stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/eeprom_ram.sv
module eeprom_ram #(
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] cells [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
        rdata_q <= cells[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/eeprom_opc_decode.sv
module eeprom_opc_decode
    import eeprom_spi_pkg::*;
#(
    parameter bit HAS_A8 = 1'b1
) (
    input  logic [7:0] opc_i,
    input  logic       busy_i,
    input  logic       wel_i,
    output fe_state_e  next_o,
    output commit_e    commit_o,
    output logic       is_read_o,
    output logic       a8_o
);
    logic addr_ok;

    if (HAS_A8) begin : g_a8
        assign addr_ok = 1'b1;
        assign a8_o    = opc_i[3];
    end else begin : g_no_a8
        assign addr_ok = ~opc_i[3];
        assign a8_o    = 1'b0;
    end

    always_comb begin
        next_o    = ST_SKIP;
        commit_o  = CM_NONE;
        is_read_o = 1'b0;
        if (busy_i && opc_i != OP_RD_STAT) begin
            next_o = ST_SKIP;
        end else if (opc_i == OP_SET_WEL) begin
            next_o   = ST_HOLD;
            commit_o = CM_SET_WEL;
        end else if (opc_i == OP_CLR_WEL) begin
            next_o   = ST_HOLD;
            commit_o = CM_CLR_WEL;
        end else if (opc_i == OP_RD_STAT) begin
            next_o = ST_SROUT;
        end else if (opc_i == OP_WR_STAT) begin
            next_o = wel_i ? ST_WSTAT : ST_SKIP;
        end else if (opc_i[7:4] == 4'h0 && addr_ok && opc_i[2:0] == OP_RD_LOW) begin
            next_o    = ST_ADDR;
            is_read_o = 1'b1;
        end else if (opc_i[7:4] == 4'h0 && addr_ok && opc_i[2:0] == OP_WR_LOW && wel_i) begin
            next_o = ST_ADDR;
        end
    end
endmodule

// File: rtl/eeprom_spi_front.sv
module eeprom_spi_front
    import eeprom_spi_pkg::*;
#(
    parameter int MEM_BYTES   = 512,
    parameter int PAGE_BYTES  = 16,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = $clog2(MEM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    input  logic [1:0]        bp_i,
    input  logic              wc_busy,
    output logic              pg_load,
    output logic [ADDR_W-1:0] pg_addr,
    output logic [7:0]        pg_data,
    output logic              wr_start,
    output logic              sr_start,
    output logic [1:0]        sr_bp,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [7:0]        mem_wdata
);
    localparam int  PW     = $clog2(PAGE_BYTES);
    localparam bit  HAS_A8 = (ADDR_W > 8);

    typedef struct packed {
        fe_state_e         st;
        logic [2:0]        cnt;
        logic [6:0]        rx;
        logic [7:0]        tx;
        logic              so;
        logic              oe;
        logic [ADDR_W-1:0] addr;
        logic              a8;
        logic              rd;
        commit_e           cmt;
        logic              wel;
        logic              pg_load;
        logic [ADDR_W-1:0] pg_addr;
        logic [7:0]        pg_data;
        logic              wr_start;
        logic              sr_start;
        logic [1:0]        sr_bp;
        logic              busy_p;
        logic              cs_p;
        logic              sck_p;
    } fe_regs_t;

    fe_regs_t r_d, r_q;

    logic [2:0] pins_s;
    logic       cs_s, sck_s, si_s;
    logic       sck_rise, sck_fall, cs_rise, busy_fall;
    logic [7:0] ram_rdata, byte_in, stat_byte, out_src;
    fe_state_e  dec_next;
    commit_e    dec_commit;
    logic       dec_rd, dec_a8;

    spi_pin_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({spi_cs_n, spi_sck, spi_si}),
        .sync_o (pins_s)
    );

    assign cs_s  = pins_s[2];
    assign sck_s = pins_s[1];
    assign si_s  = pins_s[0];

    eeprom_ram #(.DEPTH(MEM_BYTES)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (r_q.addr),
        .rdata (ram_rdata)
    );

    assign byte_in = {r_q.rx, si_s};

    eeprom_opc_decode #(.HAS_A8(HAS_A8)) u_dec (
        .opc_i     (byte_in),
        .busy_i    (wc_busy),
        .wel_i     (r_q.wel),
        .next_o    (dec_next),
        .commit_o  (dec_commit),
        .is_read_o (dec_rd),
        .a8_o      (dec_a8)
    );

    assign sck_rise  = sck_s & ~r_q.sck_p;
    assign sck_fall  = ~sck_s & r_q.sck_p;
    assign cs_rise   = cs_s & ~r_q.cs_p;
    assign busy_fall = r_q.busy_p & ~wc_busy;
    assign stat_byte = {4'hF, bp_i, r_q.wel, wc_busy};
    assign out_src   = (r_q.st == ST_RDOUT) ? ram_rdata : stat_byte;

    function automatic logic [ADDR_W-1:0] page_step(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] n;
        n = a;
        n[PW-1:0] = a[PW-1:0] + 1'b1;
        return n;
    endfunction

    always_comb begin
        r_d          = r_q;
        r_d.pg_load  = 1'b0;
        r_d.wr_start = 1'b0;
        r_d.sr_start = 1'b0;
        r_d.sck_p    = sck_s;
        r_d.cs_p     = cs_s;
        r_d.busy_p   = wc_busy;

        if (cs_s) begin
            if (cs_rise && r_q.cnt == 3'd0) begin
                case (r_q.cmt)
                    CM_SET_WEL: r_d.wel      = 1'b1;
                    CM_CLR_WEL: r_d.wel      = 1'b0;
                    CM_ARRAY:   r_d.wr_start = 1'b1;
                    CM_STATUS:  r_d.sr_start = 1'b1;
                    default:    ;
                endcase
            end
            r_d.st  = ST_IDLE;
            r_d.cnt = 3'd0;
            r_d.oe  = 1'b0;
            r_d.cmt = CM_NONE;
        end else if (r_q.st == ST_IDLE) begin
            r_d.st  = ST_OPC;
            r_d.cnt = 3'd0;
        end else begin
            if (sck_rise) begin
                r_d.cnt = r_q.cnt + 3'd1;
                r_d.rx  = {r_q.rx[5:0], si_s};
                if (r_q.cnt == 3'd7) begin
                    case (r_q.st)
                        ST_OPC: begin
                            r_d.st  = dec_next;
                            r_d.cmt = dec_commit;
                            r_d.rd  = dec_rd;
                            r_d.a8  = dec_a8;
                        end
                        ST_ADDR: begin
                            r_d.addr = ADDR_W'({r_q.a8, byte_in});
                            r_d.st   = r_q.rd ? ST_RDOUT : ST_WDATA;
                        end
                        ST_WDATA: begin
                            r_d.pg_load = 1'b1;
                            r_d.pg_addr = r_q.addr;
                            r_d.pg_data = byte_in;
                            r_d.addr    = page_step(r_q.addr);
                            r_d.cmt     = CM_ARRAY;
                        end
                        ST_WSTAT: begin
                            r_d.sr_bp = byte_in[3:2];
                            r_d.cmt   = CM_STATUS;
                            r_d.st    = ST_HOLD;
                        end
                        default: ;
                    endcase
                end
            end
            if (sck_fall && (r_q.st == ST_RDOUT || r_q.st == ST_SROUT)) begin
                if (r_q.cnt == 3'd0) begin
                    r_d.so = out_src[7];
                    r_d.tx = {out_src[6:0], 1'b0};
                    r_d.oe = 1'b1;
                    if (r_q.st == ST_RDOUT) r_d.addr = r_q.addr + 1'b1;
                end else begin
                    r_d.so = r_q.tx[7];
                    r_d.tx = {r_q.tx[6:0], 1'b0};
                end
            end
        end

        if (busy_fall) r_d.wel = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.cmt  <= CM_NONE;
            r_q.cs_p <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign spi_so    = r_q.so;
    assign spi_so_oe = r_q.oe;
    assign pg_load   = r_q.pg_load;
    assign pg_addr   = r_q.pg_addr;
    assign pg_data   = r_q.pg_data;
    assign wr_start  = r_q.wr_start;
    assign sr_start  = r_q.sr_start;
    assign sr_bp     = r_q.sr_bp;
endmodule

// File: rtl/eeprom_spi_front_chk.sv
module eeprom_spi_front_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic sck_fall,
    input logic spi_so,
    input logic spi_so_oe,
    input logic pg_load,
    input logic wel,
    input logic wc_busy
);
    assert_so_moves_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_so) |-> $past(sck_fall));

    assert_oe_after_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_so_oe) |-> $past(sck_fall));

    assert_oe_off_on_deselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_s) |=> !spi_so_oe);

    assert_load_needs_wel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pg_load |-> wel);

    assert_load_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pg_load |-> !wc_busy);

    assert_wel_clear_on_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wc_busy) |=> !wel);
endmodule

bind eeprom_spi_front eeprom_spi_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_s      (cs_s),
    .sck_fall  (sck_fall),
    .spi_so    (spi_so),
    .spi_so_oe (spi_so_oe),
    .pg_load   (pg_load),
    .wel       (r_q.wel),
    .wc_busy   (wc_busy)
);

// File: tb/eeprom_spi_front_bench.sv
module eeprom_spi_front_bench;
    localparam int MEM = 512;
    localparam int H   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic       so, so_oe;
    logic [1:0] bp = 2'b10;
    logic       busy = 1'b0;
    logic       pg_load, wr_start, sr_start;
    logic [8:0] pg_addr;
    logic [7:0] pg_data;
    logic [1:0] sr_bp;
    logic       mem_we = 1'b0;
    logic [8:0] mem_waddr = '0;
    logic [7:0] mem_wdata = '0;

    int n_chk = 0, n_fail = 0;
    logic done = 1'b0;
    logic mode3 = 1'b0;
    logic exp_wel = 1'b0;
    logic [7:0] mem_ref [MEM];
    logic [8:0] got_a [32];
    logic [7:0] got_d [32];
    int n_pg = 0, n_ws = 0, n_sr = 0;
    logic [1:0] last_bp = '0;

    always #10 clk = ~clk;

    eeprom_spi_front u_eeprom_spi_front (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .bp_i(bp), .wc_busy(busy),
        .pg_load(pg_load), .pg_addr(pg_addr), .pg_data(pg_data),
        .wr_start(wr_start), .sr_start(sr_start), .sr_bp(sr_bp),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    always @(negedge clk) begin
        if (pg_load && n_pg < 32) begin
            got_a[n_pg] = pg_addr;
            got_d[n_pg] = pg_data;
            n_pg++;
        end
        if (wr_start) n_ws++;
        if (sr_start) begin
            n_sr++;
            last_bp = sr_bp;
        end
    end

    function automatic logic [7:0] stat_exp(input logic [1:0] b, input logic w, input logic bz);
        return {4'hF, b, w, bz};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_open();
        sck = mode3;
        wait_clk(H);
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic cs_close();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (mode3) sck = 1'b0;
            si = tx[i];
            wait_clk(H);
            rx[i] = so;
            sck = 1'b1;
            wait_clk(H);
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic cmd_only(input logic [7:0] op);
        logic [7:0] rx;
        cs_open();
        xfer(op, 8, rx);
        cs_close();
    endtask

    task automatic read_status(input string req, input logic [7:0] exp);
        logic [7:0] rx;
        cs_open();
        xfer(8'h05, 8, rx);
        xfer(8'h00, 8, rx);
        chk(req, rx, exp);
        xfer(8'h00, 8, rx);
        chk(req, rx, exp);
        cs_close();
    endtask

    task automatic read_run(input logic [8:0] a, input int len);
        logic [7:0] rx;
        cs_open();
        xfer({4'h0, a[8], 3'b011}, 8, rx);
        chk("R2 oe during instruction", so_oe, 1'b0);
        xfer(a[7:0], 8, rx);
        for (int k = 0; k < len; k++) begin
            xfer(8'h00, 8, rx);
            chk("R1 R3 R4 read data", rx, mem_ref[(int'(a) + k) % MEM]);
        end
        cs_close();
        chk("R2 oe after deselect", so_oe, 1'b0);
    endtask

    initial begin
        logic [7:0] rx;
        void'($urandom(32'd4242));
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(2);
        chk("R2 reset oe", so_oe, 1'b0);
        chk("R8 reset pulses", {pg_load, wr_start, sr_start}, 3'b000);

        for (int a = 0; a < MEM; a++) begin
            mem_ref[a] = 8'($urandom);
            mem_we = 1'b1;
            mem_waddr = 9'(a);
            mem_wdata = mem_ref[a];
            wait_clk(1);
        end
        mem_we = 1'b0;

        read_status("R6 R7 status after reset", stat_exp(bp, 1'b0, 1'b0));
        mode3 = 1'b1;
        bp = 2'b01;
        read_status("R6 status mode3", stat_exp(bp, 1'b0, 1'b0));

        mode3 = 1'b0;
        read_run(9'd510, 4);
        mode3 = 1'b1;
        read_run(9'd255, 3);
        for (int it = 0; it < 16; it++) begin
            mode3 = 1'($urandom);
            read_run(9'($urandom), 1 + int'($urandom % 3));
        end
        mode3 = 1'b0;

        cs_open();
        xfer(8'hA5, 8, rx);
        xfer(8'h03, 8, rx);
        xfer(8'h00, 8, rx);
        xfer(8'h00, 8, rx);
        chk("R5 unknown code keeps output off", so_oe, 1'b0);
        xfer(8'h06, 8, rx);
        cs_close();
        read_status("R5 enable code after unknown ignored", stat_exp(bp, 1'b0, 1'b0));

        cs_open();
        xfer(8'h0A, 8, rx);
        xfer(8'h20, 8, rx);
        xfer(8'h55, 8, rx);
        cs_close();
        chk("R8 write without latch loads", n_pg, 0);
        chk("R8 write without latch start", n_ws, 0);

        cs_open();
        xfer(8'h01, 8, rx);
        xfer(8'h0C, 8, rx);
        cs_close();
        chk("R9 status write without latch", n_sr, 0);

        cmd_only(8'h06);
        read_status("R7 latch set", stat_exp(bp, 1'b1, 1'b0));
        cmd_only(8'h04);
        read_status("R7 latch cleared", stat_exp(bp, 1'b0, 1'b0));

        cmd_only(8'h06);
        cs_open();
        xfer(8'h01, 8, rx);
        xfer(8'hF4, 8, rx);
        cs_close();
        chk("R9 status write start", n_sr, 1);
        chk("R9 status write bits", last_bp, 2'b01);

        cs_open();
        xfer(8'h0A, 8, rx);
        xfer(8'h0E, 8, rx);
        for (int k = 0; k < 4; k++) xfer(8'hC0 + 8'(k), 8, rx);
        cs_close();
        chk("R8 load count", n_pg, 4);
        chk("R8 start count", n_ws, 1);
        chk("R4 R8 load addr 0", got_a[0], 9'h10E);
        chk("R8 load addr 1", got_a[1], 9'h10F);
        chk("R8 page wrap addr", got_a[2], 9'h100);
        chk("R8 load addr 3", got_a[3], 9'h101);
        chk("R8 load data", got_d[2], 8'hC2);

        busy = 1'b1;
        wait_clk(2);
        read_status("R10 status while busy", stat_exp(bp, 1'b1, 1'b1));
        cs_open();
        xfer(8'h03, 8, rx);
        xfer(8'h10, 8, rx);
        xfer(8'h00, 8, rx);
        chk("R10 read refused while busy", so_oe, 1'b0);
        cs_close();
        cmd_only(8'h04);
        read_status("R10 clear code refused while busy", stat_exp(bp, 1'b1, 1'b1));
        for (int k = 0; k < 4; k++) begin
            mem_ref[got_a[k]] = got_d[k];
            mem_we = 1'b1;
            mem_waddr = got_a[k];
            mem_wdata = got_d[k];
            wait_clk(1);
        end
        mem_we = 1'b0;
        busy = 1'b0;
        wait_clk(2);
        read_status("R11 latch cleared after busy", stat_exp(bp, 1'b0, 1'b0));
        read_run(9'h10E, 2);

        cmd_only(8'h06);
        cs_open();
        xfer(8'h02, 8, rx);
        xfer(8'h40, 8, rx);
        xfer(8'h99, 8, rx);
        xfer(8'h77, 3, rx);
        cs_close();
        chk("R12 aborted write start", n_ws, 1);
        cs_open();
        xfer(8'h06, 5, rx);
        cs_close();
        cmd_only(8'h04);
        read_status("R12 fresh decode after abort", stat_exp(bp, 1'b0, 1'b0));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule